// File: doc/BRIEF.md
# Channel Job Cycle Scheduler

This block sequences the processing core of a multi-channel voice transcoder. It runs in the master-clock domain. Once per chip-enable frame, the frame logic gives it a one-cycle start pulse, together with the channel number and the mode latched for that frame. The scheduler latches that job and holds busy for the fixed number of master-clock cycles the mode needs. It marks the last of those cycles with a one-cycle done pulse. The arithmetic itself sits elsewhere and follows the busy, channel and mode outputs.

While the reset input is low, the block sits in a low-power idle and starts no work. When reset is released, it first sweeps every per-channel state slot. For each slot it gives one write-enable cycle with an ascending address, so the state memory can clear that slot. It then reports ready.

A frame that arrives before the running job has reached its final cycle is a budget violation. The scheduler drops the running job, starts the new one and sets a sticky overrun flag. That flag stays set until it is cleared.

Top module: `chan_sched`

## Requirements
- R1: While rst_n is low, busy, done, ready, init_we and overrun are all 0, and a start pulse has no effect.
- R2: On the first clock edge after rst_n goes high, a sweep begins. It lasts NCH cycles, with init_we high and init_addr counting 0, 1, … NCH-1, one slot per cycle.
- R3: ready goes high in the cycle after the last sweep slot and stays high until the next reset. Start pulses before that are ignored, and busy stays 0.
- R4: Mode code 2'b00 (decode) keeps busy high for DEC_CYC cycles (123). Mode code 2'b01 (encode) keeps busy high for ENC_CYC cycles (123).
- R5: Mode code 2'b10 (initialised channel) keeps busy high for INIT_CYC cycles (45). Mode code 2'b11 (disabled channel) keeps busy high for DIS_CYC cycles (4).
- R6: A start sampled at a clock edge while ready is high makes busy rise in the next cycle. In that same cycle, job_chan and job_mode show the chan and mode sampled with the start.
- R7: done is high for exactly one cycle per completed job, namely the last busy cycle of that job.
- R8: A start sampled while busy is high and done is low sets overrun in the next cycle. The running job ends without a done pulse, and the new job begins with its full budget.
- R9: overrun stays high until ovr_clr is sampled high. A new overrun in the same cycle as ovr_clr wins.
- R10: A start sampled in the done cycle does not set overrun. The next job begins in the following cycle, so busy stays high across the two jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset; low holds the low-power idle |
| start | input | 1 | One-cycle job request from the frame logic |
| mode | input | 2 | Mode of the requested job (00 decode, 01 encode, 10 initialised, 11 disabled) |
| chan | input | AW | Channel of the requested job |
| ovr_clr | input | 1 | Clears the overrun flag |
| busy | output | 1 | A job is being counted |
| done | output | 1 | Last cycle of the current job |
| job_chan | output | AW | Channel of the current job |
| job_mode | output | 2 | Mode of the current job |
| init_we | output | 1 | State-clear write enable during the sweep |
| init_addr | output | AW | Slot being cleared |
| ready | output | 1 | Sweep finished; jobs are accepted |
| overrun | output | 1 | Sticky frame-overrun flag |

## Verification
A start pulse sampled at edge E shows up as busy, job_chan and job_mode in the cycle after E. The job's done pulse falls in busy cycle N, where N is the mode's budget. An overrun or ovr_clr sampled at an edge takes effect one cycle later. The sweep's first slot appears one cycle after reset release, and ready appears NCH+1 cycles after it. The bench drives inputs and samples outputs on falling edges. It counts busy cycles from the first falling edge after the start's capturing edge and records the index at which done is seen, so every result is read in the exact cycle it is due.

// File: rtl/chan_sched.sv
module chan_sched #(
  parameter int NCH      = 8,
  parameter int DEC_CYC  = 123,
  parameter int ENC_CYC  = 123,
  parameter int INIT_CYC = 45,
  parameter int DIS_CYC  = 4,
  localparam int AW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] chan,
  input  logic          ovr_clr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] job_chan,
  output logic [1:0]    job_mode,
  output logic          init_we,
  output logic [AW-1:0] init_addr,
  output logic          ready,
  output logic          overrun
);

  localparam int MAX_A = (DEC_CYC > ENC_CYC) ? DEC_CYC : ENC_CYC;
  localparam int MAX_B = (INIT_CYC > DIS_CYC) ? INIT_CYC : DIS_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  localparam logic [CW-1:0] LD_DEC  = CW'(DEC_CYC - 1);
  localparam logic [CW-1:0] LD_ENC  = CW'(ENC_CYC - 1);
  localparam logic [CW-1:0] LD_INIT = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] LD_DIS  = CW'(DIS_CYC - 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(NCH - 1);

  logic          sweep_q, ready_q, busy_q, ovr_q;
  logic [AW-1:0] addr_q, chan_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q, load;
  logic          take, last, clash;

  always_comb begin
    case (mode)
      2'b00:   load = LD_DEC;
      2'b01:   load = LD_ENC;
      2'b10:   load = LD_INIT;
      default: load = LD_DIS;
    endcase
  end

  assign take  = ready_q && start;
  assign last  = busy_q && (cnt_q == '0);
  assign clash = take && busy_q && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
      ready_q <= 1'b0;
      addr_q  <= '0;
    end else if (!sweep_q && !ready_q) begin
      sweep_q <= 1'b1;
      addr_q  <= '0;
    end else if (sweep_q) begin
      if (addr_q == LAST_SLOT) begin
        sweep_q <= 1'b0;
        ready_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      chan_q <= '0;
      mode_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      cnt_q  <= load;
      chan_q <= chan;
      mode_q <= mode;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (clash)   ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  assign busy      = busy_q;
  assign done      = last;
  assign job_chan  = chan_q;
  assign job_mode  = mode_q;
  assign init_we   = sweep_q;
  assign init_addr = addr_q;
  assign ready     = ready_q;
  assign overrun   = ovr_q;

endmodule

module chan_sched_chk #(
  parameter int NCH = 8,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic [AW-1:0] chan,
  input logic          ovr_clr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] job_chan,
  input logic [1:0]    job_mode,
  input logic          init_we,
  input logic [AW-1:0] init_addr,
  input logic          ready,
  input logic          overrun
);

  always @(posedge clk) begin
    if (!rst_n) AST_IDLE_IN_RESET: assert (!busy && !done && !ready && !init_we && !overrun); // R1
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    init_we && (init_addr != AW'(NCH - 1)) |=> init_we && (init_addr == $past(init_addr) + 1'b1)); // R2
  AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    init_we && (init_addr == AW'(NCH - 1)) |=> ready && !init_we); // R3
  AST_NOT_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !busy); // R3
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready |=> busy && job_chan == $past(chan) && job_mode == $past(mode)); // R6
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !busy); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready && busy && !done |=> overrun); // R8
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun); // R9
  AST_B2B_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    start && done && !overrun |=> !overrun && busy); // R10

endmodule

bind chan_sched chan_sched_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chan(chan),
  .ovr_clr(ovr_clr), .busy(busy), .done(done), .job_chan(job_chan),
  .job_mode(job_mode), .init_we(init_we), .init_addr(init_addr),
  .ready(ready), .overrun(overrun)
);

// File: tb/chan_sched_tb.sv
module chan_sched_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] chan = '0;
  logic          ovr_clr = 1'b0;
  logic          busy, done, init_we, ready, overrun;
  logic [AW-1:0] job_chan, init_addr;
  logic [1:0]    job_mode;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  chan_sched #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chan(chan),
    .ovr_clr(ovr_clr), .busy(busy), .done(done), .job_chan(job_chan),
    .job_mode(job_mode), .init_we(init_we), .init_addr(init_addr),
    .ready(ready), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // entered at a falling edge inside the first busy cycle of a job
  task automatic measure(input int n, input string req);
    int cnt = 0;
    int dn = 0;
    int dpos = -1;
    while (busy && cnt < 400) begin
      if (done) begin dn++; dpos = cnt; end
      cnt++;
      @(negedge clk);
    end
    chk(cnt == n, req, "busy cycles", cnt, n);
    chk(dn == 1, "R7", "done pulses", dn, 1);
    chk(dpos == n - 1, "R7", "done position", dpos, n - 1);
  endtask

  task automatic run_job(input logic [1:0] m, input logic [AW-1:0] c, input int n, input string req);
    @(negedge clk);
    start = 1'b1; mode = m; chan = c;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
    chk(job_chan == c, "R6", "job_chan", int'(job_chan), int'(c));
    chk(job_mode == m, "R6", "job_mode", int'(job_mode), int'(m));
    measure(n, req);
  endtask

  task automatic test_reset_sweep();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !done && !ready && !init_we && !overrun, "R1", "outputs in reset",
        int'({busy, done, ready, init_we, overrun}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk);
      if (i == NCH - 1) start = 1'b0;
      chk(init_we == 1'b1, "R2", "init_we in sweep", int'(init_we), 1);
      chk(init_addr == AW'(i), "R2", "init_addr", int'(init_addr), i);
      chk(ready == 1'b0 && busy == 1'b0, "R3", "not ready during sweep", int'({ready, busy}), 0);
    end
    @(negedge clk);
    chk(ready == 1'b1, "R3", "ready after sweep", int'(ready), 1);
    chk(init_we == 1'b0, "R2", "init_we after sweep", int'(init_we), 0);
    chk(busy == 1'b0, "R3", "early start ignored", int'(busy), 0);
  endtask

  task automatic test_overrun();
    @(negedge clk);
    start = 1'b1; mode = 2'b00; chan = 3'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(overrun == 1'b0, "R8", "no overrun yet", int'(overrun), 0);
    start = 1'b1; mode = 2'b01; chan = 3'd5;
    @(negedge clk);
    start = 1'b0;
    chk(overrun == 1'b1, "R8", "overrun set", int'(overrun), 1);
    chk(job_chan == 3'd5 && job_mode == 2'b01, "R8", "new job taken",
        int'({job_chan, job_mode}), int'({3'd5, 2'b01}));
    measure(123, "R8");
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R9", "overrun sticky", int'(overrun), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R9", "overrun cleared", int'(overrun), 0);
  endtask

  task automatic test_set_wins();
    @(negedge clk);
    start = 1'b1; mode = 2'b11; chan = 3'd1;
    @(negedge clk);
    start = 1'b1; mode = 2'b11; chan = 3'd3; ovr_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; ovr_clr = 1'b0;
    chk(overrun == 1'b1, "R9", "set beats clear", int'(overrun), 1);
    measure(4, "R9");
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R9", "clear after", int'(overrun), 0);
  endtask

  task automatic test_back_to_back();
    int guard = 0;
    @(negedge clk);
    start = 1'b1; mode = 2'b11; chan = 3'd6;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 20) begin guard++; @(negedge clk); end
    start = 1'b1; mode = 2'b10; chan = 3'd7;
    @(negedge clk);
    start = 1'b0;
    chk(overrun == 1'b0, "R10", "no overrun on final-cycle start", int'(overrun), 0);
    chk(busy == 1'b1 && job_chan == 3'd7, "R10", "next job seamless", int'({busy, job_chan}), int'({1'b1, 3'd7}));
    measure(45, "R10");
  endtask

  task automatic test_reset_mid_job();
    @(negedge clk);
    start = 1'b1; mode = 2'b00; chan = 3'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0 && ready == 1'b0, "R1", "reset drops job", int'({busy, ready}), 0);
  endtask

  initial begin
    test_reset_sweep();
    run_job(2'b00, 3'd0, 123, "R4");
    run_job(2'b01, 3'd7, 123, "R4");
    run_job(2'b10, 3'd3, 45, "R5");
    run_job(2'b11, 3'd1, 4, "R5");
    test_overrun();
    test_set_wins();
    test_back_to_back();
    test_reset_mid_job();
    test_reset_sweep();
    run_job(2'b11, 3'd2, 4, "R5");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule